// File: doc/BRIEF.md
# EOI Broadcast Reassert Throttle

This block handles the end-of-interrupt message that a local interrupt controller broadcasts for a vector. It checks every redirection entry, one pin per clock. A pin counts as a hit when its entry is level-triggered, its programmed vector equals the broadcast vector, and its remote-IRR flag is set. For each hit the block sends a one-cycle clear strobe to that pin's remote-IRR flag. The block then decides whether the interrupt must be delivered again. That is the case when the pin is unmasked and its input is still pending. Edge-triggered entries and entries whose remote-IRR is already clear are passed over without any effect.

A level-triggered line that stays asserted can cause an interrupt storm. To guard against this, each pin holds a counter of back-to-back reassertions. Each reassertion below the storm limit raises a service request in the same cycle. The reassertion that takes the count up to the limit sets the count back to zero and arms a single delay timer instead. That timer raises a deferred service request a fixed number of clocks later. A reassertion to a masked or idle pin sets that pin's counter to zero. Rewriting a pin's redirection entry also sets its counter to zero.

The scan is a two-state machine. In `WALK_IDLE` the block waits for a broadcast. The transition *accept* moves it to `WALK_SCAN` when `eoi_valid` is seen. `WALK_SCAN` visits pins 0 to NUM_PINS-1 in order. The transition *advance* stays in `WALK_SCAN` while pins remain. The transition *finish* goes back to `WALK_IDLE` after the last pin. While the block is in `WALK_SCAN`, `eoi_busy` is high and new broadcasts are dropped.

Top module: `eoi_reassert_throttle`

## Requirements
- R1: After reset, `eoi_busy`, `rirr_clear`, `svc_req` and `svc_delayed` are all low, and all per-pin counters and the timer are idle.
- R2: A broadcast is accepted only while `eoi_busy` is low. After the accepting edge, `eoi_busy` is high for exactly NUM_PINS cycles. A broadcast presented while busy is ignored and does not extend the scan.
- R3: Pin i is visited in cycle i+1 after the accepting edge, in ascending order. `rirr_clear` has at most one bit set, and that bit is the bit of the pin being visited.
- R4: `rirr_clear[i]` pulses in pin i's visit cycle if and only if `pin_level[i]` is 1, the vector of pin i (bits `[i*VEC_W +: VEC_W]` of `pin_vector`) equals the latched broadcast vector, and `pin_remote[i]` is 1. Edge entries (`pin_level`=0) and entries with remote-IRR clear get no strobe and keep their counters.
- R5: A hit pin with `pin_masked`=0 and `pin_pending`=1 increments its counter. If the new count is below STORM_LIMIT, `svc_req` is high in the visit cycle and `svc_delayed` is low.
- R6: A hit pin that is masked or not pending has its counter set to zero and raises no request.
- R7: When a reassertion takes the count to STORM_LIMIT, the counter is set to zero, no immediate request is made, and the timer is armed. `svc_req` and `svc_delayed` then pulse together for one cycle, exactly DELAY_CYCLES cycles after the visit cycle.
- R8: An arm that arrives while the timer is running keeps the earlier expiry. An arm in the expiry cycle itself starts a fresh delay.
- R9: A pulse on `entry_rewrite[i]` sets pin i's counter to zero. This takes priority over an update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_valid | input | 1 | Broadcast present |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_busy | output | 1 | Scan in progress; broadcasts dropped |
| pin_vector | input | NUM_PINS*VEC_W | Programmed vector of each pin, pin i at `[i*VEC_W +: VEC_W]` |
| pin_level | input | NUM_PINS | 1 = level-triggered entry |
| pin_masked | input | NUM_PINS | 1 = entry masked |
| pin_remote | input | NUM_PINS | Current remote-IRR flag of each entry |
| pin_pending | input | NUM_PINS | IRR bit: input still asserted |
| entry_rewrite | input | NUM_PINS | Pulse when a pin's entry is rewritten |
| rirr_clear | output | NUM_PINS | One-cycle clear strobe for remote-IRR |
| svc_req | output | 1 | Service request (immediate or deferred) |
| svc_delayed | output | 1 | Marks a request that comes from the timer |

## Verification
The checker watches the following on every cycle:
- a broadcast seen while idle always starts a scan;
- no scan lasts longer than NUM_PINS cycles;
- clear strobes occur only during a scan, only one at a time, and only on level entries with remote-IRR set;
- an immediate request always comes with a strobe on an unmasked, pending pin.

Some behaviour needs a history that only the bench's scenarios can provide:
- the exact count at which a pin switches from immediate to deferred service;
- the cycle in which the deferred request appears;
- an earlier expiry that survives a second arm;
- counter clears caused by masked, idle or rewritten pins.

// File: rtl/eoi_thr_pkg.sv
package eoi_thr_pkg;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_SCAN = 1'b1
    } walk_state_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/eoi_walk_fsm.sv
module eoi_walk_fsm
    import eoi_thr_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8,
    localparam int IDX_W   = idx_width(NUM_PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    output logic             busy,
    output logic             visit_en,
    output logic [IDX_W-1:0] visit_idx,
    output logic [VEC_W-1:0] cur_vector
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

    walk_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [VEC_W-1:0] vec_q, vec_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            idx_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            vec_q   <= vec_d;
        end
    end

    // Next-state logic: accept, advance, finish
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        vec_d   = vec_q;
        unique case (state_q)
            WALK_IDLE: begin
                if (eoi_valid) begin
                    state_d = WALK_SCAN;
                    idx_d   = '0;
                    vec_d   = eoi_vector;
                end
            end
            WALK_SCAN: begin
                if (idx_q == LAST_IDX) begin
                    state_d = WALK_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = WALK_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy       = 1'b0;
        visit_en   = 1'b0;
        visit_idx  = idx_q;
        cur_vector = vec_q;
        unique case (state_q)
            WALK_IDLE: begin
                busy     = 1'b0;
                visit_en = 1'b0;
            end
            WALK_SCAN: begin
                busy     = 1'b1;
                visit_en = 1'b1;
            end
            default: begin
                busy     = 1'b0;
                visit_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/eoi_pin_counters.sv
module eoi_pin_counters
    import eoi_thr_pkg::*;
#(
    parameter int NUM_PINS    = 24,
    parameter int STORM_LIMIT = 10000,
    localparam int IDX_W      = idx_width(NUM_PINS),
    localparam int CNT_W      = $clog2(STORM_LIMIT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic [IDX_W-1:0]    hit_idx,
    input  logic                bump,
    input  logic [NUM_PINS-1:0] rewrite,
    output logic                limit_hit
);

    logic [CNT_W-1:0] cnt_q [NUM_PINS];
    logic [CNT_W:0]   cnt_next;

    // Count that the visited pin would reach if it reasserts
    always_comb begin
        cnt_next  = {1'b0, cnt_q[hit_idx]} + 1'b1;
        limit_hit = bump && (cnt_next >= (CNT_W + 1)'(STORM_LIMIT));
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic sel;
        assign sel = hit && (hit_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (rewrite[g]) begin
                cnt_q[g] <= '0;
            end else if (sel) begin
                if (bump && !limit_hit) begin
                    cnt_q[g] <= cnt_next[CNT_W-1:0];
                end else begin
                    cnt_q[g] <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/eoi_delay_timer.sv
module eoi_delay_timer #(
    parameter int DELAY_CYCLES = 1000000,
    localparam int TW          = $clog2(DELAY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expire
);

    logic          running_q;
    logic [TW-1:0] left_q;

    assign expire = running_q && (left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            left_q    <= '0;
        end else if (arm && (!running_q || expire)) begin
            running_q <= 1'b1;
            left_q    <= TW'(DELAY_CYCLES - 1);
        end else if (expire) begin
            running_q <= 1'b0;
        end else if (running_q) begin
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/eoi_reassert_throttle.sv
module eoi_reassert_throttle
    import eoi_thr_pkg::*;
#(
    parameter int NUM_PINS     = 24,
    parameter int VEC_W        = 8,
    parameter int STORM_LIMIT  = 10000,
    parameter int DELAY_CYCLES = 1000000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vector,
    output logic                      eoi_busy,
    input  logic [NUM_PINS*VEC_W-1:0] pin_vector,
    input  logic [NUM_PINS-1:0]       pin_level,
    input  logic [NUM_PINS-1:0]       pin_masked,
    input  logic [NUM_PINS-1:0]       pin_remote,
    input  logic [NUM_PINS-1:0]       pin_pending,
    input  logic [NUM_PINS-1:0]       entry_rewrite,
    output logic [NUM_PINS-1:0]       rirr_clear,
    output logic                      svc_req,
    output logic                      svc_delayed
);

    localparam int IDX_W = idx_width(NUM_PINS);

    logic             visit_en;
    logic [IDX_W-1:0] visit_idx;
    logic [VEC_W-1:0] cur_vector;
    logic [VEC_W-1:0] vec_arr [NUM_PINS];
    logic             hit, reassert, limit_hit, arm, immediate, expire;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_unpack
        assign vec_arr[g] = pin_vector[g*VEC_W +: VEC_W];
    end

    eoi_walk_fsm #(
        .NUM_PINS (NUM_PINS),
        .VEC_W    (VEC_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .busy       (eoi_busy),
        .visit_en   (visit_en),
        .visit_idx  (visit_idx),
        .cur_vector (cur_vector)
    );

    always_comb begin
        hit = visit_en && pin_level[visit_idx] && pin_remote[visit_idx]
              && (vec_arr[visit_idx] == cur_vector);
        reassert  = hit && !pin_masked[visit_idx] && pin_pending[visit_idx];
        arm       = reassert && limit_hit;
        immediate = reassert && !limit_hit;
        rirr_clear = '0;
        if (hit) rirr_clear[visit_idx] = 1'b1;
    end

    eoi_pin_counters #(
        .NUM_PINS    (NUM_PINS),
        .STORM_LIMIT (STORM_LIMIT)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .hit_idx   (visit_idx),
        .bump      (reassert),
        .rewrite   (entry_rewrite),
        .limit_hit (limit_hit)
    );

    eoi_delay_timer #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .expire (expire)
    );

    assign svc_req     = immediate || expire;
    assign svc_delayed = expire;

endmodule

// File: rtl/eoi_throttle_checker.sv
module eoi_throttle_checker #(
    parameter int NUM_PINS = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                eoi_valid,
    input logic                eoi_busy,
    input logic [NUM_PINS-1:0] pin_level,
    input logic [NUM_PINS-1:0] pin_masked,
    input logic [NUM_PINS-1:0] pin_remote,
    input logic [NUM_PINS-1:0] pin_pending,
    input logic [NUM_PINS-1:0] rirr_clear,
    input logic                svc_req,
    input logic                svc_delayed
);

    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else if (eoi_busy) busy_run <= busy_run + 1'b1;
        else busy_run <= '0;
    end

    a_r2_accept_starts_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !eoi_busy) |=> eoi_busy);

    a_r2_scan_length: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 16'(NUM_PINS));

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rirr_clear));

    a_r3_strobe_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (|rirr_clear) |-> eoi_busy);

    a_r4_strobe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (|rirr_clear) |-> ((rirr_clear & pin_level & pin_remote) == rirr_clear));

    a_r5_immediate_source: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !svc_delayed) |-> (|(rirr_clear & ~pin_masked & pin_pending)));

endmodule

bind eoi_reassert_throttle eoi_throttle_checker #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eoi_valid   (eoi_valid),
    .eoi_busy    (eoi_busy),
    .pin_level   (pin_level),
    .pin_masked  (pin_masked),
    .pin_remote  (pin_remote),
    .pin_pending (pin_pending),
    .rirr_clear  (rirr_clear),
    .svc_req     (svc_req),
    .svc_delayed (svc_delayed)
);

// File: tb/tb_eoi_reassert_throttle.sv
module tb_eoi_reassert_throttle;

    localparam int N = 4;
    localparam int W = 8;
    localparam int LIM = 4;
    localparam int DLY = 40;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           eoi_valid = 1'b0;
    logic [W-1:0]   eoi_vector = '0;
    logic           eoi_busy;
    logic [N*W-1:0] pin_vector = '0;
    logic [N-1:0]   pin_level = '0, pin_masked = '0, pin_remote = '0;
    logic [N-1:0]   pin_pending = '0, entry_rewrite = '0;
    logic [N-1:0]   rirr_clear;
    logic           svc_req, svc_delayed;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int cnt [N];
    bit t_run = 0;
    int t_at = 0;
    bit exp_d;
    bit post_rw = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eoi_reassert_throttle #(
        .NUM_PINS (N), .VEC_W (W), .STORM_LIMIT (LIM), .DELAY_CYCLES (DLY)
    ) dut (
        .clk (clk), .rst_n (rst_n), .eoi_valid (eoi_valid),
        .eoi_vector (eoi_vector), .eoi_busy (eoi_busy),
        .pin_vector (pin_vector), .pin_level (pin_level),
        .pin_masked (pin_masked), .pin_remote (pin_remote),
        .pin_pending (pin_pending), .entry_rewrite (entry_rewrite),
        .rirr_clear (rirr_clear), .svc_req (svc_req), .svc_delayed (svc_delayed)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Advance to the next falling edge and check the deferred-request model (R7, R8)
    task automatic step();
        @(negedge clk);
        exp_d = t_run && (cyc == t_at);
        if (exp_d) t_run = 0;
        chk("R7 R8 deferred", {31'd0, svc_delayed}, {31'd0, exp_d});
    endtask

    task automatic idle_step();
        step();
        chk("R2 idle busy", {31'd0, eoi_busy}, 32'd0);
        chk("R4 idle strobe", {28'd0, rirr_clear}, 32'd0);
        chk("R5 idle request", {31'd0, svc_req}, {31'd0, exp_d});
    endtask

    task automatic do_eoi(input logic [W-1:0] v, input bit hold);
        logic [N-1:0] clr_seen, re_set;
        clr_seen = '0;
        re_set = '0;
        eoi_vector = v;
        eoi_valid = 1'b1;
        for (int k = 0; k < N; k++) begin
            bit match, reas, arm, imm;
            string tag;
            step();
            if (k == 0 && !hold) eoi_valid = 1'b0;
            if (k == 1) eoi_valid = 1'b0;
            match = pin_level[k] && pin_remote[k] && (pin_vector[k*W +: W] == v);
            reas = match && !pin_masked[k] && pin_pending[k];
            arm = 0;
            imm = 0;
            if (reas) begin
                if (cnt[k] + 1 >= LIM) begin
                    cnt[k] = 0;
                    arm = 1;
                end else begin
                    cnt[k] = cnt[k] + 1;
                    imm = 1;
                end
            end else if (match) begin
                cnt[k] = 0;
            end
            chk("R2 busy in scan", {31'd0, eoi_busy}, 32'd1);
            chk("R3 R4 strobe", {28'd0, rirr_clear}, match ? (32'd1 << k) : 32'd0);
            tag = reas ? (arm ? "R7 storm" : "R5 reassert") : (match ? "R6 no reassert" : "R4 skip");
            if (post_rw) tag = "R9 after rewrite";
            chk(tag, {31'd0, svc_req}, {31'd0, (imm | exp_d)});
            if (arm && !t_run) begin
                t_run = 1;
                t_at = cyc + DLY;
            end
            if (match) clr_seen[k] = 1'b1;
            if (reas) re_set[k] = 1'b1;
        end
        idle_step();
        pin_remote = (pin_remote & ~clr_seen) | re_set;
    endtask

    task automatic rewrite_pin(input int p);
        entry_rewrite = '0;
        entry_rewrite[p] = 1'b1;
        idle_step();
        entry_rewrite = '0;
        cnt[p] = 0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) cnt[i] = 0;
        pin_vector = {8'h30, 8'h30, 8'h31, 8'h30};
        pin_level = 4'b0111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk("R1 busy", {31'd0, eoi_busy}, 32'd0);
        chk("R1 strobe", {28'd0, rirr_clear}, 32'd0);
        chk("R1 request", {31'd0, svc_req}, 32'd0);
        chk("R1 deferred", {31'd0, svc_delayed}, 32'd0);

        // Sweep over remote, mask and pending patterns
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cf;
            cf = 8'(c);
            pin_remote = cf[3:0];
            pin_masked = {2'b00, cf[5:4]};
            pin_pending = {1'b1, ~cf[7], ~cf[6], 1'b1};
            do_eoi(8'h30, cf[0]);
            do_eoi(8'h31, 1'b0);
            if (c % 9 == 0) rewrite_pin(int'(cf[1:0]));
        end

        // Deferred timing and keep-earlier expiry
        pin_vector = {8'h77, 8'h77, 8'h77, 8'h30};
        pin_level = 4'b1111;
        pin_masked = '0;
        pin_pending = '1;
        pin_remote = 4'b0001;
        repeat (DLY + 5) idle_step();
        rewrite_pin(0);
        post_rw = 1;
        repeat (LIM - 1) do_eoi(8'h30, 1'b0);
        post_rw = 0;
        repeat (LIM + 1) do_eoi(8'h30, 1'b0);
        repeat (LIM) do_eoi(8'h30, 1'b1);
        repeat (DLY + 10) idle_step();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule